// File: doc/BRIEF.md
# Page-Bounded Sequential Stream Prefetcher

This block watches the demand misses of one cache level. It passes each miss on to the memory request port. It also learns which 4 KB pages are being walked in sequence. A page becomes an active stream when two successive misses land in it less than 256 bytes apart. From then on, the block requests the block that follows the most recent miss. That prefetched block returns into a small per-stream buffer and is never written into the cache.

The cache controller probes the buffer with a lookup address. On a hit it takes the block in the same cycle. The hit frees the buffer entry and arms a prefetch of the next block, so a steady sequential walk stays one block ahead. Up to eight pages are tracked at once. A miss to an untracked page takes a free slot, or else the slot used least recently. Demand misses always win the shared request port, and no prefetch ever leaves its page.

Top module: `stream_prefetcher`

## Requirements
- R1: A demand miss appears on the request port in the same cycle, with the full miss address and `mem_req_is_pf`=0. `miss_ready` follows `mem_req_ready`.
- R2: A single miss in a page issues no prefetch. A second accepted miss in the same page, less than 256 bytes from the previous miss of that page, raises a prefetch request in the next cycle. Its address is the 64-byte block after the second miss, with the low 6 bits zero.
- R3: Two successive misses in one page that are 256 or more bytes apart issue no prefetch.
- R4: No prefetch is requested outside the page of its stream. A second miss inside the last block of a page (offset bits [11:6] all ones) issues none.
- R5: While `miss_valid` is high the request port carries the demand miss, and a waiting prefetch is held back until the port is free of demand.
- R6: A prefetch response is stored as the buffer entry of its stream. A lookup of any byte address inside that block gives `lookup_hit`=1 and the stored data in the same cycle. A lookup of any other block gives `lookup_hit`=0.
- R7: A lookup hit frees the buffer entry, so the same lookup misses afterwards. In the next cycle a prefetch of the following block is requested, provided that block is in the same page.
- R8: Eight pages are tracked. When all eight are in use, a miss to a new page replaces the page touched least recently by a miss or a lookup hit, and the replaced page loses its history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Demand miss present |
| miss_addr | input | 32 | Byte address of the demand miss |
| miss_ready | output | 1 | Demand miss accepted this cycle |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Request address (demand byte address or prefetch block address) |
| mem_req_is_pf | output | 1 | 1 for a prefetch, 0 for a demand miss |
| pf_rsp_valid | input | 1 | Prefetch data returning |
| pf_rsp_addr | input | 32 | Block address of the returning prefetch |
| pf_rsp_data | input | 64 | Returned block data |
| lookup_valid | input | 1 | Stream buffer probe |
| lookup_addr | input | 32 | Byte address probed |
| lookup_hit | output | 1 | Probe found a buffered block |
| lookup_data | output | 64 | Data of the buffered block |

## Verification
Demand forwarding and lookup results are combinational, so the bench samples them 1 ns after it drives the inputs at the falling edge. The stream table changes only at a rising edge. A prefetch armed by a miss or a lookup hit therefore becomes visible at the falling edge after that rising edge. The bench samples it there, before the next rising edge accepts it. Responses are driven for one full cycle and probed one cycle later. Each expected prefetch address comes from a bench function that applies the distance, page and block rules to the two miss addresses.

// File: rtl/spf_pkg.sv
package spf_pkg;
  localparam int AW     = 32;
  localparam int DW     = 64;
  localparam int PG_W   = 12;
  localparam int BLK_W  = 6;
  localparam int NSTR   = 8;
  localparam int WIN    = 256;
  localparam int SID_W  = $clog2(NSTR);
  localparam int PN_W   = AW - PG_W;
  localparam int BI_W   = PG_W - BLK_W;

  typedef struct packed {
    logic            vld;
    logic [PN_W-1:0] page;
    logic [PG_W-1:0] last_off;
    logic            pend;
    logic [BI_W-1:0] pf_blk;
    logic            fly;
    logic [BI_W-1:0] fly_blk;
    logic            bvld;
    logic [BI_W-1:0] b_blk;
  } strm_t;

  function automatic logic [PN_W-1:0] page_of(input logic [AW-1:0] a);
    return a[AW-1:PG_W];
  endfunction

  function automatic logic [PG_W-1:0] off_of(input logic [AW-1:0] a);
    return a[PG_W-1:0];
  endfunction

  function automatic logic [BI_W-1:0] blk_of(input logic [AW-1:0] a);
    return a[PG_W-1:BLK_W];
  endfunction

  function automatic logic is_close(input logic [PG_W-1:0] o1, input logic [PG_W-1:0] o2);
    logic [PG_W-1:0] d;
    d = (o1 > o2) ? (o1 - o2) : (o2 - o1);
    return d < PG_W'(WIN);
  endfunction

  function automatic logic has_next(input logic [BI_W-1:0] b);
    return b != {BI_W{1'b1}};
  endfunction

  function automatic logic [AW-1:0] blk_addr(input logic [PN_W-1:0] p, input logic [BI_W-1:0] b);
    return {p, b, {BLK_W{1'b0}}};
  endfunction
endpackage

// File: rtl/spf_pick.sv
module spf_pick #(
  parameter int N = 8,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/spf_lru.sv
module spf_lru #(
  parameter int N = 8,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          touch,
  input  logic [IW-1:0] touch_idx,
  output logic [IW-1:0] victim
);
  logic [IW-1:0] age [N];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) age[i] <= IW'(i);
    end else if (touch) begin
      for (int i = 0; i < N; i++) begin
        if (IW'(i) == touch_idx) age[i] <= '0;
        else if (age[i] < age[touch_idx]) age[i] <= age[i] + 1'b1;
      end
    end
  end

  always_comb begin
    victim = '0;
    for (int i = 0; i < N; i++)
      if (age[i] == IW'(N - 1)) victim = IW'(i);
  end
endmodule

// File: rtl/stream_prefetcher.sv
module stream_prefetcher
  import spf_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          miss_valid,
  input  logic [AW-1:0] miss_addr,
  output logic          miss_ready,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_req_addr,
  output logic          mem_req_is_pf,
  input  logic          pf_rsp_valid,
  input  logic [AW-1:0] pf_rsp_addr,
  input  logic [DW-1:0] pf_rsp_data,
  input  logic          lookup_valid,
  input  logic [AW-1:0] lookup_addr,
  output logic          lookup_hit,
  output logic [DW-1:0] lookup_data
);
  strm_t           st  [NSTR];
  logic [DW-1:0]   buf_data [NSTR];

  logic [NSTR-1:0] match_vec, hit_vec, pend_vec, fill_vec, free_vec;
  logic            match_any, hit_any, pf_any, free_any;
  logic [SID_W-1:0] match_idx, hit_idx, pf_idx, free_idx, lru_idx, alloc_idx, touch_idx;
  logic            miss_fire, pf_fire, alloc, touch;

  for (genvar g = 0; g < NSTR; g++) begin : g_vec
    assign match_vec[g] = st[g].vld && (st[g].page == page_of(miss_addr));
    assign hit_vec[g]   = lookup_valid && st[g].bvld &&
                          (st[g].page == page_of(lookup_addr)) &&
                          (st[g].b_blk == blk_of(lookup_addr));
    assign pend_vec[g]  = st[g].pend && !st[g].fly;
    assign fill_vec[g]  = pf_rsp_valid && st[g].fly &&
                          (blk_addr(st[g].page, st[g].fly_blk) ==
                           blk_addr(page_of(pf_rsp_addr), blk_of(pf_rsp_addr)));
    assign free_vec[g]  = !st[g].vld;
  end

  spf_pick #(.N(NSTR)) u_pick_match (.req(match_vec), .any(match_any), .idx(match_idx));
  spf_pick #(.N(NSTR)) u_pick_hit   (.req(hit_vec),   .any(hit_any),   .idx(hit_idx));
  spf_pick #(.N(NSTR)) u_pick_pf    (.req(pend_vec),  .any(pf_any),    .idx(pf_idx));
  spf_pick #(.N(NSTR)) u_pick_free  (.req(free_vec),  .any(free_any),  .idx(free_idx));

  assign miss_fire = miss_valid && mem_req_ready;
  assign pf_fire   = !miss_valid && pf_any && mem_req_ready;
  assign alloc     = miss_fire && !match_any;
  assign alloc_idx = free_any ? free_idx : lru_idx;
  assign touch     = miss_fire || hit_any;
  assign touch_idx = miss_fire ? (match_any ? match_idx : alloc_idx) : hit_idx;

  spf_lru #(.N(NSTR)) u_lru (
    .clk(clk), .rst_n(rst_n), .touch(touch), .touch_idx(touch_idx), .victim(lru_idx)
  );

  assign miss_ready    = mem_req_ready;
  assign mem_req_valid = miss_valid || pf_any;
  assign mem_req_is_pf = !miss_valid;
  assign mem_req_addr  = miss_valid ? miss_addr : blk_addr(st[pf_idx].page, st[pf_idx].pf_blk);

  assign lookup_hit  = hit_any;
  assign lookup_data = buf_data[hit_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSTR; i++) begin
        st[i]       <= '0;
        buf_data[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NSTR; i++) begin
        if (fill_vec[i]) begin
          st[i].fly   <= 1'b0;
          st[i].bvld  <= 1'b1;
          st[i].b_blk <= st[i].fly_blk;
          buf_data[i] <= pf_rsp_data;
        end
        if (pf_fire && pf_idx == SID_W'(i)) begin
          st[i].pend    <= 1'b0;
          st[i].fly     <= 1'b1;
          st[i].fly_blk <= st[i].pf_blk;
        end
        if (hit_any && hit_idx == SID_W'(i)) begin
          st[i].bvld <= 1'b0;
          if (has_next(st[i].b_blk)) begin
            st[i].pend   <= 1'b1;
            st[i].pf_blk <= st[i].b_blk + 1'b1;
          end
        end
        if (miss_fire && match_any && match_idx == SID_W'(i)) begin
          st[i].last_off <= off_of(miss_addr);
          if (is_close(st[i].last_off, off_of(miss_addr)) && has_next(blk_of(miss_addr))) begin
            st[i].pend   <= 1'b1;
            st[i].pf_blk <= blk_of(miss_addr) + 1'b1;
          end
        end
        if (alloc && alloc_idx == SID_W'(i)) begin
          st[i].vld      <= 1'b1;
          st[i].page     <= page_of(miss_addr);
          st[i].last_off <= off_of(miss_addr);
          st[i].pend     <= 1'b0;
          st[i].fly      <= 1'b0;
          st[i].bvld     <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/spf_chk.sv
module spf_chk #(
  parameter int N = 8,
  parameter int AW = 32,
  parameter int BLK_W = 6,
  parameter int PG_W = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          miss_valid,
  input logic [AW-1:0] miss_addr,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic          mem_req_is_pf,
  input logic [AW-1:0] mem_req_addr,
  input logic          lookup_valid,
  input logic [AW-1:0] lookup_addr,
  input logic          lookup_hit,
  input logic [N-1:0]  hit_vec,
  input logic [N-1:0]  match_vec
);
  // R5: the port serves the demand whenever one is present
  a_r5_demand_wins: assert property (@(posedge clk) disable iff (!rst_n)
    miss_valid |-> (mem_req_valid && !mem_req_is_pf && mem_req_addr == miss_addr));

  // R4: a prefetch target is always a later block of the same page, never block 0
  a_r4_pf_inside_page: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_is_pf) |-> (mem_req_addr[PG_W-1:BLK_W] != '0 && mem_req_addr[BLK_W-1:0] == '0));

  // R8: no two slots hold the same page
  a_r8_pages_unique: assert property (@(posedge clk) disable iff (!rst_n)
    miss_valid |-> $onehot0(match_vec));

  // R6: at most one buffer entry answers a lookup
  a_r6_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  // R7: a hit consumes its block, so a held lookup misses next cycle
  a_r7_hit_consumed: assert property (@(posedge clk) disable iff (!rst_n)
    (lookup_valid && lookup_hit) |=> !(lookup_valid && lookup_hit && $stable(lookup_addr)));
endmodule

bind stream_prefetcher spf_chk #(
  .N(spf_pkg::NSTR), .AW(spf_pkg::AW), .BLK_W(spf_pkg::BLK_W), .PG_W(spf_pkg::PG_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_addr(miss_addr),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_is_pf(mem_req_is_pf), .mem_req_addr(mem_req_addr),
  .lookup_valid(lookup_valid), .lookup_addr(lookup_addr), .lookup_hit(lookup_hit),
  .hit_vec(hit_vec), .match_vec(match_vec)
);

// File: tb/stream_prefetcher_tb_top.sv
module stream_prefetcher_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        miss_valid = 1'b0;
  logic [31:0] miss_addr = '0;
  logic        miss_ready;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b1;
  logic [31:0] mem_req_addr;
  logic        mem_req_is_pf;
  logic        pf_rsp_valid = 1'b0;
  logic [31:0] pf_rsp_addr = '0;
  logic [63:0] pf_rsp_data = '0;
  logic        lookup_valid = 1'b0;
  logic [31:0] lookup_addr = '0;
  logic        lookup_hit;
  logic [63:0] lookup_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  stream_prefetcher dut_i (.*);

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Bench rule for the prefetch due after two successive misses in one page
  function automatic bit want_pf(input logic [31:0] a1, input logic [31:0] a2, output logic [31:0] tgt);
    int d;
    d = int'(a2[11:0]) - int'(a1[11:0]);
    if (d < 0) d = -d;
    tgt = {a2[31:12], a2[11:6] + 6'd1, 6'd0};
    return (a1[31:12] == a2[31:12]) && (d < 256) && (a2[11:6] != 6'h3f);
  endfunction

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  // Drive one miss for one cycle; check R1 forwarding; return 1 ns after the next falling edge
  task automatic do_miss(input logic [31:0] a);
    @(negedge clk);
    miss_valid = 1'b1; miss_addr = a;
    #1;
    check(mem_req_valid && !mem_req_is_pf && mem_req_addr == a && miss_ready, "R1 demand forward",
          {31'd0, mem_req_is_pf, mem_req_addr}, {32'd0, a});
    @(negedge clk);
    miss_valid = 1'b0;
    #1;
  endtask

  task automatic expect_pf(input bit exp, input logic [31:0] a, input string req);
    if (exp)
      check(mem_req_valid && mem_req_is_pf && mem_req_addr == a, req,
            {31'd0, mem_req_valid, mem_req_addr}, {32'd1, a});
    else
      check(!mem_req_valid, req, {63'd0, mem_req_valid}, 64'd0);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] t;
    void'($urandom(32'h5eed1234));
    do_reset();
    #1;
    check(!mem_req_valid && !lookup_hit, "R1 reset idle", {62'd0, mem_req_valid, lookup_hit}, 64'd0);

    // R2: single miss then a close one
    do_miss(32'h1000_0100);
    expect_pf(0, 0, "R2 single miss no prefetch");
    do_miss(32'h1000_0140);
    expect_pf(1, 32'h1000_0180, "R2 close pair prefetch");

    // R6: response fills buffer, lookups
    @(negedge clk);
    pf_rsp_valid = 1'b1; pf_rsp_addr = 32'h1000_0180; pf_rsp_data = 64'hA5A5_0001_DEAD_BEEF;
    @(negedge clk);
    pf_rsp_valid = 1'b0;
    lookup_valid = 1'b1; lookup_addr = 32'h1000_01C0;
    #1;
    check(!lookup_hit, "R6 other block misses", {63'd0, lookup_hit}, 64'd0);
    @(negedge clk);
    lookup_addr = 32'h1000_0188;
    #1;
    check(lookup_hit && lookup_data == 64'hA5A5_0001_DEAD_BEEF, "R6 buffered hit", lookup_data, 64'hA5A5_0001_DEAD_BEEF);
    @(negedge clk);
    #1;
    check(!lookup_hit, "R7 hit consumed", {63'd0, lookup_hit}, 64'd0);
    lookup_valid = 1'b0;
    #0.1;
    expect_pf(1, 32'h1000_01C0, "R7 next block armed");

    // R3: exactly 256 apart
    do_miss(32'h2000_0000);
    do_miss(32'h2000_0100);
    expect_pf(0, 0, "R3 distance 256 no prefetch");
    do_miss(32'h2000_01FF);
    expect_pf(1, 32'h2000_0200, "R2 distance 255 prefetch");

    // R4: last block of page
    do_miss(32'h3000_0F80);
    do_miss(32'h3000_0FC8);
    expect_pf(0, 0, "R4 no prefetch past page end");

    // R5: demand beats waiting prefetch
    do_miss(32'h4000_0200);
    do_miss(32'h4000_0210);
    expect_pf(1, 32'h4000_0240, "R2 prefetch pending");
    miss_valid = 1'b1; miss_addr = 32'h5000_0000;
    #0.1;
    check(mem_req_valid && !mem_req_is_pf && mem_req_addr == 32'h5000_0000, "R5 demand wins port",
          {31'd0, mem_req_is_pf, mem_req_addr}, 64'h5000_0000);
    @(negedge clk);
    miss_valid = 1'b0;
    #1;
    expect_pf(1, 32'h4000_0240, "R5 prefetch after demand");

    // R8: LRU replacement
    do_reset();
    for (int k = 0; k < 8; k++) do_miss({20'h60000 + 20'(k), 12'h100});
    do_miss(32'h6000_0800);
    expect_pf(0, 0, "R3 far miss no prefetch");
    do_miss(32'h6000_8100);
    do_miss(32'h6000_1140);
    expect_pf(0, 0, "R8 evicted page lost history");
    do_miss(32'h6000_0840);
    expect_pf(1, 32'h6000_0880, "R8 recent page kept");

    // Random pairs in fresh pages
    do_reset();
    for (int k = 0; k < 60; k++) begin
      logic [31:0] a1, a2;
      bit e;
      a1 = {20'h70000 + 20'(k), 12'($urandom)};
      if ($urandom % 2) a2 = {a1[31:12], a1[11:0] + 12'($urandom % 300) - 12'd150};
      else              a2 = {a1[31:12], 12'($urandom)};
      do_miss(a1);
      expect_pf(0, 0, "R2 random first miss");
      do_miss(a2);
      e = want_pf(a1, a2, t);
      expect_pf(e, t, e ? "R2 random pair prefetch" : "R3/R4 random pair quiet");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule